// File: doc/BRIEF.md
# Stereo Overrange Level Classifier

This block grades each stereo capture sample by how close it comes to the 16-bit full-scale limit. The samples are 18-bit two's complement and are taken before any clipping, so excursions beyond full scale stay visible. For each channel the block takes the absolute magnitude and compares it with three fixed thresholds: about -1 dB, 0 dB and +1 dB relative to a full scale of 32767. The result is a 2-bit grade per channel.

Samples arrive on a valid/ready stream. The block never applies back-pressure. `in_ready` is high whenever reset is low, so a sample is accepted on every clock edge where `in_valid` is high and reset is low. The two grades are registered on the accepting edge. They stay unchanged until the next accepted sample, so a status reader can sample them at any time. The grades are also offered packed into one status byte. The grades refresh with every sample and do not hold a peak.

Top module: `ovr_level_classifier`

## Requirements
- R1: A channel whose accepted sample has magnitude below 29204 gets code 0.
- R2: A magnitude from 29204 up to 32766 gives code 1. A magnitude exactly at 29204 is code 1.
- R3: A magnitude from 32767 up to 36764 gives code 2 (overrange). A magnitude exactly at 32767 is code 2.
- R4: A magnitude of 36765 or more gives code 3. A magnitude exactly at 36765 is code 3.
- R5: Negative samples are graded by absolute value. The most negative input, -131072, gives code 3.
- R6: The left and right channels are graded independently of each other.
- R7: The codes change only on the clock edge that accepts a sample, and are visible after that edge. While `in_valid` is low they hold, whatever the sample inputs do.
- R8: Synchronous reset clears both codes and the status byte to zero.
- R9: `status_byte` carries the left code in bits 1:0 and the right code in bits 3:2. Bits 7:4 are zero.
- R10: `in_ready` is high whenever `rst` is low, and low while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Block accepts a sample (high out of reset) |
| in_left | input | 18 | Left sample, signed, before clipping |
| in_right | input | 18 | Right sample, signed, before clipping |
| code_left | output | 2 | Left overrange grade |
| code_right | output | 2 | Right overrange grade |
| status_byte | output | 8 | Packed grades: left in 1:0, right in 3:2 |

## Verification
The embedded assertions watch three things on every cycle: both codes hold while no sample is accepted, reset leaves them at zero, and a zero input or the most negative input maps to its fixed grade. Only the bench scenarios can show the following:
- each threshold boundary lands on the higher code;
- a negative sample mirrors its positive counterpart;
- the two channels stay independent under mixed pairs;
- the status-byte packing is correct;
- the ready behaviour during reset is correct.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int NUM_CH = 2;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    OVR_BELOW = 2'd0,
    OVR_NEAR  = 2'd1,
    OVR_OVER  = 2'd2,
    OVR_FAR   = 2'd3
  } ovr_code_t;
endpackage

// File: rtl/ovr_abs.sv
module ovr_abs #(
  parameter int W = 18
) (
  input  logic signed [W-1:0] smp,
  output logic        [W-1:0] mag
);
  // W-bit unsigned result holds the negated most negative value exactly
  always_comb begin
    if (smp[W-1]) mag = W'(-smp);
    else          mag = W'(smp);
  end
endmodule

// File: rtl/ovr_grade.sv
module ovr_grade
  import ovr_pkg::*;
#(
  parameter int W     = 18,
  parameter int LO_TH = 29204,
  parameter int FS_TH = 32767,
  parameter int HI_TH = 36765
) (
  input  logic [W-1:0] mag,
  output ovr_code_t    code
);
  localparam logic [W-1:0] LO_V = W'(LO_TH);
  localparam logic [W-1:0] FS_V = W'(FS_TH);
  localparam logic [W-1:0] HI_V = W'(HI_TH);

  // Equality with a threshold selects the higher grade
  always_comb begin
    if      (mag >= HI_V) code = OVR_FAR;
    else if (mag >= FS_V) code = OVR_OVER;
    else if (mag >= LO_V) code = OVR_NEAR;
    else                  code = OVR_BELOW;
  end
endmodule

// File: rtl/ovr_level_classifier.sv
module ovr_level_classifier
  import ovr_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int LO_TH    = 29204,
  parameter int FS_TH    = 32767,
  parameter int HI_TH    = 36765
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic [CODE_W-1:0]   code_left,
  output logic [CODE_W-1:0]   code_right,
  output logic [7:0]          status_byte
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] smp  [NUM_CH];
  logic [SAMPLE_W-1:0] mag  [NUM_CH];
  ovr_code_t           grade[NUM_CH];
  ovr_code_t           code_q[NUM_CH];
  logic                take;

  assign in_ready = ~rst;
  assign take     = in_valid & in_ready;
  assign smp[0]   = in_left;
  assign smp[1]   = in_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ovr_abs #(.W(SAMPLE_W)) u_abs (
      .smp(signed'(smp[ch])),
      .mag(mag[ch])
    );

    ovr_grade #(
      .W(SAMPLE_W), .LO_TH(LO_TH), .FS_TH(FS_TH), .HI_TH(HI_TH)
    ) u_grade (
      .mag(mag[ch]),
      .code(grade[ch])
    );

    always_ff @(posedge clk) begin
      if (rst)       code_q[ch] <= OVR_BELOW;
      else if (take) code_q[ch] <= grade[ch];
    end
  end

  assign code_left   = code_q[0];
  assign code_right  = code_q[1];
  assign status_byte = {4'b0000, code_q[1], code_q[0]};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (code_left == 2'd0 && code_right == 2'd0)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(code_left) && $stable(code_right))); // R7

  AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_left == '0) |=> code_left == 2'd0); // R1

  AST_ZERO_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_right == '0) |=> code_right == 2'd0); // R1

  AST_MOSTNEG_LEFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_left == MOST_NEG) |=> code_left == 2'd3); // R5

  AST_MOSTNEG_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_right == MOST_NEG) |=> code_right == 2'd3); // R5
endmodule

// File: tb/ovr_level_classifier_tb.sv
module ovr_level_classifier_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_left = '0;
  logic [17:0] in_right = '0;
  logic [1:0]  code_left, code_right;
  logic [7:0]  status_byte;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ovr_level_classifier u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .code_left(code_left), .code_right(code_right), .status_byte(status_byte)
  );

  // columns: left, right, expected left code, expected right code
  localparam int NV = 12;
  localparam int VEC [NV][4] = '{
    '{0,       0,       0, 0},
    '{29203,  -29203,   0, 0},
    '{29204,  -29204,   1, 1},
    '{32766,  -32766,   1, 1},
    '{32767,  -32767,   2, 2},
    '{36764,  -36764,   2, 2},
    '{36765,  -36765,   3, 3},
    '{131071, -131072,  3, 3},
    '{-32768,  100,     2, 0},
    '{0,       40000,   0, 3},
    '{-29204,  32767,   1, 2},
    '{1000,   -36766,   0, 3}
  };

  task automatic chk(string req, int act, int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // drive one accepted sample, then sample outputs at the following negedge
  task automatic put(int l, int r);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 18'(l);
    in_right = 18'(r);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset left", code_left, 0);
    chk("R8 reset right", code_right, 0);
    chk("R8 reset status", status_byte, 0);
    chk("R10 ready low in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready high", in_ready, 1);

    // R1 R2 R3 R4 R5 R6 R9: table of boundary and mixed pairs
    for (int i = 0; i < NV; i++) begin
      put(VEC[i][0], VEC[i][1]);
      chk("R1-4 left grade", code_left, VEC[i][2]);
      chk("R6 right grade", code_right, VEC[i][3]);
      chk("R9 status pack", status_byte, VEC[i][3] * 4 + VEC[i][2]);
    end

    // R7: hold while idle even though the inputs move
    put(36765, 0);
    @(negedge clk);
    in_left  = 18'(0);
    in_right = 18'(40000);
    repeat (3) @(negedge clk);
    chk("R7 hold left", code_left, 3);
    chk("R7 hold right", code_right, 0);

    // R7: an accepted sample replaces the previous code without stickiness
    put(5, -5);
    chk("R7 refresh left", code_left, 0);
    chk("R5 small negative", code_right, 0);

    // R8: reset in mid-run clears the codes
    put(-131072, 131071);
    chk("R5 most negative", code_left, 3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 midrun clear", status_byte, 0);
    chk("R10 ready drops", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready back", in_ready, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule